// File: doc/BRIEF.md
# Sequential Prefetch Line Buffer for Slow Flash

This block sits between a processor's byte-wide instruction or data fetch port and a flash array that is read one 32-bit word at a time and needs several clock cycles per read. Every flash read brings in a whole aligned word, that is four neighbouring bytes, and keeps it in a single line register together with its word address and a valid flag. A later byte request that falls inside the kept word is answered in the same cycle. A request anywhere else stalls the processor by dropping `cpu_ready` while the new word is read. Straight-line code therefore runs at full speed three fetches out of four, while a jump to another word still pays the whole flash delay.

The processor holds `cpu_req` and `cpu_addr` stable while `cpu_ready` is low and takes `cpu_data` in the cycle where both `cpu_req` and `cpu_ready` are high. The flash side has no handshake. The block raises `flash_rd` and keeps `flash_addr` stable for exactly `LAT` cycles, and the flash must present the word on `flash_rdata` in the last of those cycles. The `line_flush` input throws away the kept word after the flash contents have been rewritten.

The controller has three states. IDLE serves hits, and on a miss it takes the IDLE-to-FETCH transition. FETCH drives the flash read; when the counter reaches its last cycle it takes the FETCH-to-IDLE transition and loads the line. A flush seen before the last FETCH cycle takes the FETCH-to-STALE transition. STALE finishes the flash read without loading the line and returns to IDLE through the STALE-to-IDLE transition.

Top module: `flash_prefetch_line`

## Requirements
- R1: After reset the line is empty: with `cpu_req` low, `cpu_ready` is high and `flash_rd` is low, and the first request of any address misses.
- R2: A request whose `cpu_addr[ADDR_W-1:2]` equals the kept word address while the line is valid is a hit. In that same cycle `cpu_ready` is high, `cpu_data` is byte `cpu_addr[1:0]` of the kept word (byte 0 = bits 7:0, byte 3 = bits 31:24), and no flash read starts.
- R3: A miss holds `cpu_ready` low for exactly `LAT`+1 cycles: the cycle of the miss and the `LAT` cycles of the flash read. The requested byte is then served in the following cycle.
- R4: A flash read keeps `flash_rd` high for exactly `LAT` consecutive cycles with `flash_addr` equal to `cpu_addr[ADDR_W-1:2]` of the missing request and stable throughout. `cpu_ready` is low in every one of those cycles.
- R5: After a word has been loaded, requests to each of its four bytes in any order are hits.
- R6: A request outside the kept word misses even if the next word in address order is requested, and the new word replaces the old one.
- R7: A `line_flush` pulse while no read is in progress clears the valid flag. The next request to the formerly kept word misses and returns the current flash contents.
- R8: A `line_flush` during a flash read, in any of its cycles, discards that word. The still-pending request then misses again, so the stall lasts 2·(`LAT`+1) cycles in total.
- R9: A request in the same cycle as `line_flush` is treated as a miss even if it matches the kept word.
- R10: With `cpu_req` low, `cpu_ready` stays high and no flash read starts, even while `line_flush` is pulsed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor byte request |
| cpu_addr | input | ADDR_W | Byte address of the request |
| line_flush | input | 1 | Discard the kept word |
| cpu_ready | output | 1 | Request served in this cycle (or no request) |
| cpu_data | output | 8 | Requested byte, valid when `cpu_req` and `cpu_ready` are high |
| flash_rd | output | 1 | Flash read in progress |
| flash_addr | output | ADDR_W-2 | Word address of the flash read |
| flash_rdata | input | 32 | Flash word, valid in the last cycle of a read |

## Verification
A wrong valid flag or a stale word address shows at the ports in the very cycle of the next request to the affected word. A lost invalidation serves the old byte with `cpu_ready` high, and a valid flag that was cleared by mistake gives an unexpected stall. A miscounted wait shows as `cpu_ready` returning a cycle early or late, or, when the word is captured before the flash has it, as a wrong byte on the first hit after the fill. A failure to drop a fetch that was flushed part-way shows as a stall that is `LAT`+1 cycles too short, together with stale data.

// File: rtl/fpb_pkg.sv
package fpb_pkg;

    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int WORD_W = LANES * LANE_W;
    localparam int SEL_W  = $clog2(LANES);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_STALE = 2'd2
    } fpb_state_e;

endpackage

// File: rtl/fpb_line.sv
module fpb_line
    import fpb_pkg::*;
#(
    parameter int TAG_W = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                load,
    input  logic [TAG_W-1:0]    load_tag,
    input  logic [WORD_W-1:0]   load_word,
    input  logic [TAG_W-1:0]    look_tag,
    input  logic [SEL_W-1:0]    look_sel,
    output logic                match,
    output logic [LANE_W-1:0]   look_byte
);

    logic                valid_q;
    logic [TAG_W-1:0]    tag_q;
    logic [WORD_W-1:0]   word_q;
    logic [LANE_W-1:0]   lane [LANES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
        end else if (clear) begin
            valid_q <= 1'b0;
        end else if (load) begin
            valid_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (load) begin
            tag_q  <= load_tag;
            word_q <= load_word;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane[g] = word_q[g*LANE_W +: LANE_W];
    end

    assign match     = valid_q && (tag_q == look_tag);
    assign look_byte = lane[look_sel];

endmodule

// File: rtl/fpb_ctrl.sv
module fpb_ctrl
    import fpb_pkg::*;
#(
    parameter int LAT   = 4,
    parameter int TAG_W = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req,
    input  logic [TAG_W-1:0]    req_tag,
    input  logic                hit,
    input  logic                flush,
    output logic                ready,
    output logic                rd,
    output logic [TAG_W-1:0]    rd_tag,
    output logic                load
);

    localparam int CNT_W = $clog2(LAT + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LAT - 1);

    fpb_state_e          state_q, state_d;
    logic [CNT_W-1:0]    cnt_q;
    logic [TAG_W-1:0]    tag_q;
    logic                last;

    assign last = (cnt_q == CNT_LAST);

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req && !hit) state_d = ST_FETCH;
            end
            ST_FETCH: begin
                if (last)       state_d = ST_IDLE;
                else if (flush) state_d = ST_STALE;
            end
            ST_STALE: begin
                if (last) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register, wait counter and miss address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            tag_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE) begin
                cnt_q <= '0;
                if (req && !hit) tag_q <= req_tag;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        ready = 1'b0;
        rd    = 1'b0;
        load  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                ready = !req || hit;
            end
            ST_FETCH: begin
                rd   = 1'b1;
                load = last && !flush;
            end
            ST_STALE: begin
                rd = 1'b1;
            end
            default: begin
                ready = 1'b0;
            end
        endcase
    end

    assign rd_tag = tag_q;

endmodule

// File: rtl/flash_prefetch_line.sv
module flash_prefetch_line
    import fpb_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LAT    = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cpu_req,
    input  logic [ADDR_W-1:0]     cpu_addr,
    input  logic                  line_flush,
    output logic                  cpu_ready,
    output logic [LANE_W-1:0]     cpu_data,
    output logic                  flash_rd,
    output logic [ADDR_W-3:0]     flash_addr,
    input  logic [WORD_W-1:0]     flash_rdata
);

    localparam int TAG_W = ADDR_W - SEL_W;

    logic              tag_match;
    logic              hit;
    logic              load;
    logic [TAG_W-1:0]  req_tag;
    logic [SEL_W-1:0]  req_sel;

    assign req_tag = cpu_addr[ADDR_W-1:SEL_W];
    assign req_sel = cpu_addr[SEL_W-1:0];
    assign hit     = tag_match && !line_flush;

    fpb_line #(
        .TAG_W (TAG_W)
    ) line_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (line_flush),
        .load      (load),
        .load_tag  (flash_addr),
        .load_word (flash_rdata),
        .look_tag  (req_tag),
        .look_sel  (req_sel),
        .match     (tag_match),
        .look_byte (cpu_data)
    );

    fpb_ctrl #(
        .LAT   (LAT),
        .TAG_W (TAG_W)
    ) ctrl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (cpu_req),
        .req_tag (req_tag),
        .hit     (hit),
        .flush   (line_flush),
        .ready   (cpu_ready),
        .rd      (flash_rd),
        .rd_tag  (flash_addr),
        .load    (load)
    );

endmodule

// File: rtl/fpb_checker.sv
module fpb_checker #(
    parameter int LAT   = 4,
    parameter int TAG_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic              cpu_ready,
    input logic              flash_rd,
    input logic [TAG_W-1:0]  flash_addr
);

    localparam int RUN_W = $clog2(LAT + 2);

    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n)        run_q <= '0;
        else if (flash_rd) run_q <= run_q + 1'b1;
        else               run_q <= '0;
    end

    // R4: a read never lasts longer than LAT cycles
    a_r4_rd_bound: assert property (@(posedge clk) disable iff (!rst_n)
        flash_rd |-> (run_q < RUN_W'(LAT)));

    // R4: a read that ends has lasted exactly LAT cycles
    a_r4_rd_full: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flash_rd) |-> (run_q == RUN_W'(LAT)));

    // R4: the word address holds during a read
    a_r4_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_rd && $past(flash_rd)) |-> $stable(flash_addr));

    // R3: the processor is stalled while flash is being read
    a_r3_stall_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        flash_rd |-> !cpu_ready);

    // R2: a served request starts no flash read
    a_r2_hit_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_ready && !flash_rd) |=> !flash_rd);

    // R10: no request, no flash read
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_req && !flash_rd) |=> !flash_rd);

endmodule

bind flash_prefetch_line fpb_checker #(
    .LAT   (LAT),
    .TAG_W (TAG_W)
) fpb_checker_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_req    (cpu_req),
    .cpu_ready  (cpu_ready),
    .flash_rd   (flash_rd),
    .flash_addr (flash_addr)
);

// File: tb/flash_prefetch_line_tb.sv
module flash_prefetch_line_tb_top;

    localparam int ADDR_W = 16;
    localparam int LAT    = 4;
    localparam int TAG_W  = ADDR_W - 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cpu_req = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic              line_flush = 1'b0;
    logic              cpu_ready;
    logic [7:0]        cpu_data;
    logic              flash_rd;
    logic [TAG_W-1:0]  flash_addr;
    logic [31:0]       flash_rdata;

    int n_cmp = 0;
    int n_bad = 0;
    int gen = 0;
    int rd_run = 0;
    bit running = 0;
    bit done = 0;

    always #4 clk = ~clk;

    flash_prefetch_line #(.ADDR_W(ADDR_W), .LAT(LAT)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_req     (cpu_req),
        .cpu_addr    (cpu_addr),
        .line_flush  (line_flush),
        .cpu_ready   (cpu_ready),
        .cpu_data    (cpu_data),
        .flash_rd    (flash_rd),
        .flash_addr  (flash_addr),
        .flash_rdata (flash_rdata)
    );

    function automatic logic [31:0] fword(input int t, input int g);
        return 32'(t * 32'h0103_0507 + g * 32'h1111_1111 + 32'h0F1E_2D3C);
    endfunction

    // flash model: the word appears only in the LAT-th read cycle
    always @(posedge clk) begin
        if (!rst_n || !flash_rd) rd_run <= 0;
        else                     rd_run <= rd_run + 1;
    end
    assign flash_rdata = (flash_rd && rd_run >= LAT - 1) ? fword(int'(flash_addr), gen)
                                                         : 32'hDEAD_BEEF;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference model
    bit          m_valid = 0;
    int          m_tag = 0;
    logic [31:0] m_word = '0;
    bit          m_busy = 0;
    int          m_left = 0;
    int          m_mtag = 0;
    bit          m_drop = 0;

    always @(negedge clk) begin
        if (running) begin
            bit hit, e_ready;
            string tg;
            hit = 0;
            e_ready = 0;
            if (!m_busy) begin
                hit = cpu_req && m_valid && (m_tag == int'(cpu_addr[ADDR_W-1:2])) && !line_flush;
                e_ready = !cpu_req || hit;
            end
            tg = m_busy ? "R3" : (!cpu_req ? "R10" : (hit ? "R2" : "R3"));
            chk(cpu_ready == e_ready, tg, 32'(cpu_ready), 32'(e_ready));
            chk(flash_rd == m_busy, "R4", 32'(flash_rd), 32'(m_busy));
            if (m_busy && flash_rd)
                chk(int'(flash_addr) == m_mtag, "R4", 32'(flash_addr), 32'(m_mtag));
            if (hit)
                chk(cpu_data == m_word[8*cpu_addr[1:0] +: 8], "R2",
                    32'(cpu_data), 32'(m_word[8*cpu_addr[1:0] +: 8]));
            if (!m_busy) begin
                if (line_flush) m_valid = 0;
                if (cpu_req && !hit) begin
                    m_busy = 1; m_left = LAT; m_drop = 0;
                    m_mtag = int'(cpu_addr[ADDR_W-1:2]);
                end
            end else begin
                if (line_flush) begin m_drop = 1; m_valid = 0; end
                m_left--;
                if (m_left == 0) begin
                    m_busy = 0;
                    if (!m_drop) begin
                        m_valid = 1; m_tag = m_mtag; m_word = fword(m_mtag, gen);
                    end
                end
            end
        end
    end

    // fetch a byte; flush_at >= 0 pulses line_flush in that stall cycle index
    task automatic fetch(input int a, input int flush_at, output int stall,
                         output logic [7:0] data);
        @(posedge clk); #1;
        cpu_req = 1; cpu_addr = ADDR_W'(a); line_flush = (flush_at == 0);
        stall = 0;
        forever begin
            @(negedge clk);
            if (cpu_ready) break;
            stall++;
            @(posedge clk); #1;
            line_flush = (stall == flush_at);
        end
        data = cpu_data;
    endtask

    task automatic idle(input int n, input bit fl);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            cpu_req = 0; line_flush = fl && (i == 0);
        end
        @(posedge clk); #1;
        line_flush = 0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        int st;
        logic [7:0] d;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        running = 1;
        @(negedge clk);
        chk(cpu_ready == 1 && flash_rd == 0, "R1", {cpu_ready, flash_rd}, 32'b10);

        fetch(16'h0100, -1, st, d);
        chk(st == LAT + 1, "R1", st, LAT + 1);
        chk(d == fword(16'h0040, 0)[7:0], "R3", d, fword(16'h0040, 0)[7:0]);
        for (int b = 3; b >= 1; b--) begin
            fetch(16'h0100 + b, -1, st, d);
            chk(st == 0, "R5", st, 0);
        end
        fetch(16'h0104, -1, st, d);
        chk(st == LAT + 1, "R6", st, LAT + 1);
        fetch(16'h0102, -1, st, d);
        chk(st == LAT + 1, "R6", st, LAT + 1);

        idle(3, 0);
        gen = 1;
        fetch(16'h0101, -1, st, d);
        chk(st == 0, "R5", st, 0);
        idle(2, 1);
        fetch(16'h0101, -1, st, d);
        chk(st == LAT + 1, "R7", st, LAT + 1);
        chk(d == fword(16'h0040, 1)[15:8], "R7", d, fword(16'h0040, 1)[15:8]);

        fetch(16'h0103, 0, st, d);
        chk(st == LAT + 1, "R9", st, LAT + 1);

        fetch(16'h0200, 2, st, d);
        chk(st == 2 * (LAT + 1), "R8", st, 2 * (LAT + 1));
        fetch(16'h0201, -1, st, d);
        chk(st == 0, "R8", st, 0);
        fetch(16'h0300, LAT, st, d);
        chk(st == 2 * (LAT + 1), "R8", st, 2 * (LAT + 1));

        idle(4, 1);
        for (int i = 0; i < 60; i++) begin
            fetch((i * 37 + (i % 5)) & 16'h003F, (i % 11 == 3) ? 1 : -1, st, d);
            if (i % 9 == 0) idle(1, i % 2 == 0);
        end
        idle(2, 0);
        done = 1;
        summary();
    end

endmodule